// File: doc/BRIEF.md
# Chien Search Root Finder and Bit Corrector

This block finishes the decoding of a binary triple-error-correcting cyclic code of length 31 over GF(32). An upstream stage supplies an error-locator polynomial of degree up to three together with the received 31-bit word, which is kept in a buffer register. The block then walks through every bit position, one per clock. It tests whether the matching power of alpha is a root of the locator and, if so, marks that bit for inversion. Each locator term lives in its own register and is advanced by a fixed constant multiply on every step. The polynomial is never evaluated from scratch.

When the walk ends, the block compares the number of roots found with the degree of the locator. If they agree, it returns the received word with the marked bits inverted. If they differ, the error pattern lies beyond what the code can correct: the block returns the received word untouched and raises a flag. A single-cycle done pulse marks the point where the result is valid. The result then stays on the outputs until the next pulse.

Top module: `chien_correct`

## Requirements
- R1: While reset is held, and after it is released until the first result, `done` and `uncorrectable` are 0 and `word_out` is all zeros.
- R2: A `start` sampled high while the block is idle captures `rx_word` and `locator`. Coefficient i of the locator occupies bits [5i+4:5i] of `locator`, and each coefficient is a GF(32) element in polynomial basis under the primitive polynomial x^5+x^2+1. `done` rises at the 31st rising edge after the edge that sampled `start`.
- R3: Bit j of the word (j = 0..30) is in error exactly when the sum over i of sigma_i·alpha^(-i·j) is zero.
- R4: The locator degree is the highest index i in 1..3 whose coefficient is nonzero, or 0 if all three are zero. When the number of roots equals this degree, `word_out` is `rx_word` with every root position inverted and `uncorrectable` is 0.
- R5: When the number of roots differs from the degree, `word_out` equals the captured `rx_word` unchanged and `uncorrectable` is 1. This includes an all-zero locator, where every position is a root.
- R6: A `start` that arrives while a search is running has no effect on that search or its result.
- R7: `word_out` and `uncorrectable` keep their values from one `done` pulse until the next.
- R8: `done` is high for exactly one clock cycle per search.
- R9: A locator equal to the constant 1 finds no roots, and the word passes through with `uncorrectable` low.
- R10: Errors at the first position (bit 0) and the last position (bit 30) are both found and corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a search when idle |
| locator | input | 20 | Four packed GF(32) locator coefficients, index 0 at the low bits |
| rx_word | input | 31 | Received word to be corrected |
| done | output | 1 | One-cycle pulse when the result is valid |
| word_out | output | 31 | Corrected (or passed-through) word |
| uncorrectable | output | 1 | Root count did not match locator degree |

## Verification
Two things happen in the same cycle: the root test of the final position, bit 30, and the closing comparison of the root count with the degree. In that cycle the count must already include the hit that is being recorded. The bench provokes this by placing an error at bit 30, alone and together with an error at bit 0. The scoreboard then expects an exact recovery with the flag low. If the last hit were missed, the count would fall one short of the degree, and the word would come back uncorrected with the flag set.

// File: rtl/bch_chien_pkg.sv
package bch_chien_pkg;

    localparam int GF_M     = 5;
    localparam int CODE_N   = (1 << GF_M) - 1;
    localparam int MAX_T    = 3;
    localparam int STEP_W   = $clog2(CODE_N);
    localparam int CNT_W    = $clog2(CODE_N + 1);

    // low bits of the primitive polynomial x^5 + x^2 + 1
    localparam logic [GF_M-1:0] PRIM_LOW = 5'b00101;

    typedef logic [GF_M-1:0]   gf_t;
    typedef logic [CODE_N-1:0] word_t;

    typedef enum logic [0:0] {ST_IDLE, ST_SCAN} scan_state_e;

    // multiply by alpha
    function automatic gf_t gf_xtime(gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1]) r = r ^ PRIM_LOW;
        return r;
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // alpha^e for 0 <= e < CODE_N
    function automatic gf_t gf_apow(int e);
        gf_t r;
        r = gf_t'(1);
        for (int k = 0; k < CODE_N; k++) begin
            if (k < e) r = gf_xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/chien_term.sv
module chien_term
    import bch_chien_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  gf_t  coef,
    output gf_t  term
);
    // stepping by alpha^(-IDX) so that step j evaluates at alpha^(-j)
    localparam int  EXP_K  = (CODE_N - (IDX % CODE_N)) % CODE_N;
    localparam gf_t STEP_K = gf_apow(EXP_K);

    gf_t term_q;

    always_ff @(posedge clk) begin
        if (rst)       term_q <= '0;
        else if (load) term_q <= coef;
        else if (step) term_q <= gf_mul(term_q, STEP_K);
    end

    assign term = term_q;

    // R3: a term moves only on load or step
    p_term_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(term_q));

endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
    import bch_chien_pkg::*;
#(
    parameter int LEN = CODE_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load,
    output logic              scan,
    output logic              last,
    output logic [STEP_W-1:0] pos
);
    scan_state_e       st_q;
    logic [STEP_W-1:0] pos_q;

    assign load = start && (st_q == ST_IDLE);
    assign scan = (st_q == ST_SCAN);
    assign last = scan && (pos_q == STEP_W'(LEN - 1));
    assign pos  = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_SCAN;
                        pos_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (last) st_q <= ST_IDLE;
                    else      pos_q <= pos_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R3: the walk never leaves the code length
    p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
        scan |-> (int'(pos_q) < LEN));

    // R2: an accepted start begins the walk at bit 0
    p_load_enter_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (scan && pos_q == '0));

    // R2: the final position returns the sequencer to idle
    p_scan_exit_r2: assert property (@(posedge clk) disable iff (rst)
        last |=> (st_q == ST_IDLE));

endmodule

// File: rtl/chien_fix.sv
module chien_fix
    import bch_chien_pkg::*;
#(
    parameter int NC = MAX_T + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     scan,
    input  logic                     last,
    input  logic [STEP_W-1:0]        pos,
    input  word_t                    rx_word,
    input  logic [NC-1:0][GF_M-1:0]  coef_in,
    input  logic [NC-1:0][GF_M-1:0]  terms,
    output logic                     done,
    output word_t                    word_out,
    output logic                     unc
);
    word_t            buf_q;
    word_t            mask_q;
    word_t            mask_next;
    word_t            word_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] deg_q;
    logic [CNT_W-1:0] deg_in;
    logic             done_q;
    logic             unc_q;
    gf_t              sum;
    logic             hit;

    always_comb begin
        deg_in = '0;
        for (int i = 1; i < NC; i++) begin
            if (coef_in[i] != '0) deg_in = CNT_W'(i);
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NC; i++) sum = sum ^ terms[i];
    end

    assign hit       = scan && (sum == '0);
    assign cnt_next  = cnt_q + CNT_W'(hit);
    assign mask_next = mask_q | (word_t'(hit) << pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
            deg_q  <= '0;
            word_q <= '0;
            unc_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                buf_q  <= rx_word;
                mask_q <= '0;
                cnt_q  <= '0;
                deg_q  <= deg_in;
            end else if (scan) begin
                mask_q <= mask_next;
                cnt_q  <= cnt_next;
                if (last) begin
                    done_q <= 1'b1;
                    unc_q  <= (cnt_next != deg_q);
                    word_q <= (cnt_next == deg_q) ? (buf_q ^ mask_next) : buf_q;
                end
            end
        end
    end

    assign done     = done_q;
    assign word_out = word_q;
    assign unc      = unc_q;

    // R8: done never lasts two cycles
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6: the buffered word is frozen across a running search
    p_buf_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        scan |=> $stable(buf_q));

    // R5: a flagged result is the buffered word itself
    p_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        (done_q && unc_q) |-> (word_q == buf_q));

    // R4: a corrected result differs in exactly degree-many bits
    p_flip_count_r4: assert property (@(posedge clk) disable iff (rst)
        (done_q && !unc_q) |-> ($countones(word_q ^ buf_q) == int'(deg_q)));

    // R7: outputs change only on the closing step
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !last |=> ($stable(word_q) && $stable(unc_q)));

endmodule

// File: rtl/chien_correct.sv
module chien_correct
    import bch_chien_pkg::*;
#(
    parameter int T_CORR = MAX_T
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [(T_CORR+1)*GF_M-1:0]    locator,
    input  logic [CODE_N-1:0]             rx_word,
    output logic                          done,
    output logic [CODE_N-1:0]             word_out,
    output logic                          uncorrectable
);
    localparam int NC = T_CORR + 1;

    logic                     load;
    logic                     scan;
    logic                     last;
    logic [STEP_W-1:0]        pos;
    logic [NC-1:0][GF_M-1:0]  coefs;
    logic [NC-1:0][GF_M-1:0]  terms;

    chien_ctrl #(.LEN(CODE_N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .scan  (scan),
        .last  (last),
        .pos   (pos)
    );

    for (genvar g = 0; g < NC; g++) begin : g_term
        assign coefs[g] = locator[g*GF_M +: GF_M];

        chien_term #(.IDX(g)) u_term (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .step (scan),
            .coef (coefs[g]),
            .term (terms[g])
        );
    end

    chien_fix #(.NC(NC)) u_fix (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .scan     (scan),
        .last     (last),
        .pos      (pos),
        .rx_word  (rx_word),
        .coef_in  (coefs),
        .terms    (terms),
        .done     (done),
        .word_out (word_out),
        .unc      (uncorrectable)
    );

    // R6: a start during a search does not restart it
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        (scan && !last && start) |=> scan);

endmodule

// File: tb/sim_chien_correct.sv
module sim_chien_correct;
    localparam int M  = 5;
    localparam int N  = 31;
    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NC*M-1:0] loc = '0;
    logic [N-1:0]    rxw = '0;
    logic            done;
    logic [N-1:0]    wout;
    logic            unc;

    always #4 clk = ~clk;

    chien_correct u0 (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .locator       (loc),
        .rx_word       (rxw),
        .done          (done),
        .word_out      (wout),
        .uncorrectable (unc)
    );

    typedef struct {
        logic [N-1:0] w;
        bit           u;
        int           at;
        string        tag;
    } exp_t;

    exp_t         sbq[$];
    exp_t         got;
    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc = 0;
    bit           finished = 0;
    bit           prev_done = 0;
    bit           have_last = 0;
    logic [N-1:0] last_w;
    bit           last_u;

    logic [4:0]   gexp[0:N-1];
    int           glog[0:N];
    logic [15:0]  gbin;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, logic [N-1:0] act, logic [N-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [4:0] bmul(logic [4:0] a, logic [4:0] b);
        if (a == 0 || b == 0) return 5'd0;
        return gexp[(glog[a] + glog[b]) % N];
    endfunction

    // direct evaluation of the locator at alpha^(-j) for every bit j
    function automatic void model(input logic [NC*M-1:0] l, input logic [N-1:0] w,
                                  output logic [N-1:0] ew, output bit eu);
        int           roots = 0;
        int           deg = 0;
        logic [N-1:0] m = '0;
        for (int i = 1; i < NC; i++) if (l[i*M +: M] != 0) deg = i;
        for (int j = 0; j < N; j++) begin
            logic [4:0] s = 5'd0;
            for (int i = 0; i < NC; i++) s = s ^ bmul(l[i*M +: M], gexp[(i * (N - j)) % N]);
            if (s == 0) begin
                m[j] = 1'b1;
                roots++;
            end
        end
        eu = (roots != deg);
        ew = eu ? w : (w ^ m);
    endfunction

    function automatic logic [N-1:0] encode(logic [15:0] msg);
        logic [N-1:0] cw = '0;
        for (int b = 0; b < 16; b++) if (msg[b]) cw = cw ^ (N'(gbin) << b);
        return cw;
    endfunction

    function automatic logic [NC*M-1:0] locate(int ne, int p0, int p1, int p2);
        logic [4:0]      s[0:NC-1];
        int              p[0:2];
        logic [NC*M-1:0] r;
        p[0] = p0; p[1] = p1; p[2] = p2;
        s[0] = 5'd1; s[1] = 5'd0; s[2] = 5'd0; s[3] = 5'd0;
        for (int q = 0; q < ne; q++) begin
            for (int k = NC - 1; k >= 1; k--) s[k] = s[k] ^ bmul(gexp[p[q]], s[k-1]);
        end
        for (int k = 0; k < NC; k++) r[k*M +: M] = s[k];
        return r;
    endfunction

    // driver: push expectation, pulse start, wait for the search to finish
    task automatic apply(logic [N-1:0] w, logic [NC*M-1:0] l,
                         logic [N-1:0] ew, bit eu, string tag);
        exp_t e;
        @(negedge clk);
        if (have_last) begin
            chk(wout == last_w, "R7 word held", wout, last_w);
            chk(unc == last_u, "R7 flag held", N'(unc), N'(last_u));
        end
        rxw   = w;
        loc   = l;
        start = 1'b1;
        e.w = ew; e.u = eu; e.at = cyc + 32; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        start = 1'b0;
        rxw   = '0;
        loc   = '0;
        repeat (33) @(negedge clk);
    endtask

    task automatic apply_err(logic [15:0] msg, int ne, int p0, int p1, int p2, string tag);
        logic [N-1:0] cw = encode(msg);
        logic [N-1:0] r  = cw;
        if (ne > 0) r[p0] = ~r[p0];
        if (ne > 1) r[p1] = ~r[p1];
        if (ne > 2) r[p2] = ~r[p2];
        apply(r, locate(ne, p0, p1, p2), cw, 1'b0, tag);
    endtask

    task automatic apply_loc(logic [N-1:0] w, logic [NC*M-1:0] l, string tag);
        logic [N-1:0] ew;
        bit           eu;
        model(l, w, ew, eu);
        apply(w, l, ew, eu, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: pop expectations as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk(!done, "R8 done one cycle", N'(done), '0);
            prev_done = done;
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2 unexpected done", wout, '0);
                end else begin
                    got = sbq.pop_front();
                    chk(wout == got.w, {got.tag, " word"}, wout, got.w);
                    chk(unc == got.u, {got.tag, " flag"}, N'(unc), N'(got.u));
                    chk(cyc == got.at, "R2 done latency", N'(cyc), N'(got.at));
                    last_w    = got.w;
                    last_u    = got.u;
                    have_last = 1;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit         inset[0:N-1];
        logic [4:0] gg[0:15];
        int         dg;

        gexp[0] = 5'd1;
        for (int k = 1; k < N; k++)
            gexp[k] = gexp[k-1][4] ? ({gexp[k-1][3:0], 1'b0} ^ 5'b00101) : {gexp[k-1][3:0], 1'b0};
        for (int k = 0; k < N; k++) glog[gexp[k]] = k;
        glog[0] = 0;

        for (int k = 0; k < N; k++) inset[k] = 0;
        for (int c = 1; c <= 5; c += 2) begin
            int v = c;
            for (int q = 0; q < 5; q++) begin
                inset[v] = 1;
                v = (2 * v) % N;
            end
        end
        for (int k = 0; k < 16; k++) gg[k] = 5'd0;
        gg[0] = 5'd1;
        dg = 0;
        for (int e = 1; e < N; e++) begin
            if (inset[e]) begin
                for (int k = dg + 1; k >= 0; k--)
                    gg[k] = (k > 0 ? gg[k-1] : 5'd0) ^ bmul(gexp[e], gg[k]);
                dg++;
            end
        end
        for (int k = 0; k < 16; k++) gbin[k] = gg[k][0];

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done at reset", N'(done), '0);
        chk(wout == '0, "R1 word at reset", wout, '0);
        chk(unc == 1'b0, "R1 flag at reset", N'(unc), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && wout == '0 && unc == 1'b0, "R1 idle after reset", wout, '0);

        // R9: constant locator, nothing flips
        apply_err(16'hA5C3, 0, 0, 0, 0, "R9 no errors");
        // R10: first and last positions, last one alone
        apply_err(16'h1234, 2, 0, 30, 0, "R10 ends");
        apply_err(16'hFFFF, 1, 30, 0, 0, "R10 last bit");
        apply_err(16'h0001, 3, 0, 15, 30, "R10 three spread");

        // R3 and R4: random codewords with 0 to 3 errors
        for (int v = 0; v < 40; v++) begin
            int ne = v % 4;
            int p[0:2];
            for (int q = 0; q < 3; q++) begin
                bit dup;
                do begin
                    p[q] = $urandom_range(0, N - 1);
                    dup  = 0;
                    for (int r = 0; r < q; r++) if (p[r] == p[q]) dup = 1;
                end while (dup);
            end
            apply_err(16'($urandom), ne, p[0], p[1], p[2], "R4 random recovery");
        end

        // R5: degree 2 with no roots in GF(32)
        apply_loc(31'h2BAD_F00D, {5'd0, 5'd1, 5'd1, 5'd1}, "R5 rootless");
        // R5: all-zero locator, every bit a root, degree 0
        apply_loc(31'h0F0F_0F0F, '0, "R5 zero locator");
        // R3: arbitrary locators judged by direct evaluation
        for (int v = 0; v < 10; v++)
            apply_loc(31'($urandom), 20'($urandom), "R3 arbitrary locator");

        // R6: second start in the middle of a running search
        begin
            logic [N-1:0] cw = encode(16'h5A5A);
            logic [N-1:0] r  = cw;
            exp_t         e;
            r[3] = ~r[3]; r[17] = ~r[17];
            @(negedge clk);
            rxw = r; loc = locate(2, 3, 17, 0); start = 1'b1;
            e.w = cw; e.u = 1'b0; e.at = cyc + 32; e.tag = "R6 busy start";
            sbq.push_back(e);
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            rxw = 31'h7FFF_FFFF; loc = 20'h00421; start = 1'b1;
            @(negedge clk);
            start = 1'b0; rxw = '0; loc = '0;
            repeat (40) @(negedge clk);
        end

        apply_err(16'hBEEF, 1, 7, 0, 0, "R4 after busy start");

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R2 missing done", N'(sbq.size()), '0);
        finish_run();
    end

endmodule